// File: doc/BRIEF.md
# Blanking-Interval Line Enable Controller

This block decides, one video line at a time, whether a special treatment applies to the line now starting inside the vertical blanking interval. It holds one enable mask per field parity. Each mask has one bit for each of sixteen consecutive blanking lines. Software loads the masks through a byte-wide write port, with four byte registers in total. The timing generator supplies the field parity, the line number and a line-start strobe. On each strobe the block looks up the matching mask bit and latches a flag that stays constant for the whole line.

The meaning of a set bit depends on the video standard selected. Under 525-line (NTSC) timing, a set bit removes the black-level pedestal from that line. Under 625-line (PAL) timing, a set bit opens that line for teletext insertion. Outside the sixteen-line window, and for any clear bit, the default applies: the pedestal stays on and no teletext is inserted. The pedestal and teletext datapaths that consume these flags are outside this block.

Top module: `vbi_line_enable`

## Requirements
- R1: While reset is asserted, both mask registers clear to all zeros and both outputs are 0. After reset, a strobe on any line yields 0 on both outputs until a mask bit is written.
- R2: A write with `wr_en_i`=1 stores `wr_data_i` according to its address. Address 0x15 holds odd-field mask bits 7:0. Address 0x16 holds odd-field mask bits 15:8. Address 0x17 holds even-field mask bits 7:0. Address 0x18 holds even-field mask bits 15:8. Mask bit n governs line 7+n, so bit 0 is line 7 and bit 15 is line 22.
- R3: When `field_odd_i`=1 at a strobe and the line number lies between 7 and 22, the flag is odd-field mask bit (line−7).
- R4: When `field_odd_i`=0 at a strobe and the line number lies between 7 and 22, the flag is even-field mask bit (line−7).
- R5: With `mode_pal_i`=0 (NTSC) at the strobe, `ped_suppress_o` carries the flag and `ttx_insert_o` is 0.
- R6: With `mode_pal_i`=1 (PAL) at the strobe, `ttx_insert_o` carries the flag and `ped_suppress_o` is 0.
- R7: A strobe on a line number below 7 or above 22 drives both outputs to 0.
- R8: The outputs change only in the clock cycle after a strobe. Between strobes they hold their value, even when the field, line, mode or mask registers change.
- R9: A register write in the same cycle as a strobe does not affect the flag latched by that strobe. It takes effect from the next strobe.
- R10: A write to any address other than 0x15 to 0x18 changes no mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 5 | Register sub-address |
| wr_data_i | input | 8 | Register write data |
| field_odd_i | input | 1 | 1 = odd field, 0 = even field |
| line_num_i | input | 10 | Line number within the current field |
| mode_pal_i | input | 1 | 0 = NTSC, 1 = PAL |
| line_start_i | input | 1 | One-cycle strobe at the start of each line |
| ped_suppress_o | output | 1 | 1 = remove the pedestal on this line (NTSC) |
| ttx_insert_o | output | 1 | 1 = teletext enabled on this line (PAL) |

## Verification
A write lands in the mask on the same clock edge that samples it. A strobe moves the looked-up flag to the outputs one edge later. The bench therefore drives every input on the falling clock edge and reads the outputs on the following falling edge, half a cycle after the edge that updates them. For the hold requirement, the bench changes the field, line, mode and registers without a strobe and reads the outputs again several cycles later. For the same-cycle write, the first check is taken one edge after the combined strobe and write, and a second strobe shows the new value.

// File: rtl/vbi_le_pkg.sv
package vbi_le_pkg;

  typedef enum logic {
    STD_NTSC = 1'b0,
    STD_PAL  = 1'b1
  } vid_std_e;

  localparam int FLD_ODD  = 0;
  localparam int FLD_EVEN = 1;
  localparam int NUM_FLD  = 2;

endpackage

// File: rtl/vbi_le_rst_sync.sv
module vbi_le_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_nxt;

  always_comb begin
    sync_nxt = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_nxt;
    end
  end

  assign rst_n_sync_o = sync_q[STAGES-1];

endmodule

// File: rtl/vbi_le_regs.sv
module vbi_le_regs
  import vbi_le_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 8,
  parameter int WIN_LINES = 16,
  parameter int BASE_ADDR = 'h15
) (
  input  logic                 clk,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  output logic [WIN_LINES-1:0] odd_mask_o,
  output logic [WIN_LINES-1:0] even_mask_o
);

  localparam int BYTES = WIN_LINES / DATA_W;
  localparam int NREG  = NUM_FLD * BYTES;

  logic [NUM_FLD-1:0][WIN_LINES-1:0] mask_q;
  logic [NUM_FLD-1:0][WIN_LINES-1:0] mask_nxt;
  logic [NREG-1:0]                   hit;

  // One address decoder per byte register.
  for (genvar g = 0; g < NREG; g++) begin : g_dec
    assign hit[g] = (wr_addr_i == ADDR_W'(BASE_ADDR + g));
  end

  always_comb begin
    mask_nxt = mask_q;
    for (int g = 0; g < NREG; g++) begin
      if (hit[g]) begin
        mask_nxt[g / BYTES][(g % BYTES) * DATA_W +: DATA_W] = wr_data_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
    end else if (wr_en_i) begin
      mask_q <= mask_nxt;
    end
  end

  assign odd_mask_o  = mask_q[FLD_ODD];
  assign even_mask_o = mask_q[FLD_EVEN];

endmodule

// File: rtl/vbi_le_lookup.sv
module vbi_le_lookup #(
  parameter int LINE_W     = 10,
  parameter int WIN_LINES  = 16,
  parameter int FIRST_LINE = 7
) (
  input  logic [WIN_LINES-1:0] odd_mask_i,
  input  logic [WIN_LINES-1:0] even_mask_i,
  input  logic                 field_odd_i,
  input  logic [LINE_W-1:0]    line_num_i,
  output logic                 line_flag_o
);

  logic [WIN_LINES-1:0] mask_sel;

  assign mask_sel = field_odd_i ? odd_mask_i : even_mask_i;

  // Lines outside the window match no entry and keep the default 0.
  always_comb begin
    line_flag_o = 1'b0;
    for (int i = 0; i < WIN_LINES; i++) begin
      if (line_num_i == LINE_W'(FIRST_LINE + i)) begin
        line_flag_o = mask_sel[i];
      end
    end
  end

endmodule

// File: rtl/vbi_le_out.sv
module vbi_le_out
  import vbi_le_pkg::*;
(
  input  logic clk,
  input  logic rst_ni,
  input  logic line_start_i,
  input  logic line_flag_i,
  input  logic mode_pal_i,
  output logic ped_suppress_o,
  output logic ttx_insert_o
);

  vid_std_e std;
  logic     ped_q, ped_nxt;
  logic     ttx_q, ttx_nxt;

  assign std = vid_std_e'(mode_pal_i);

  always_comb begin
    ped_nxt = line_flag_i && (std == STD_NTSC);
    ttx_nxt = line_flag_i && (std == STD_PAL);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ped_q <= 1'b0;
      ttx_q <= 1'b0;
    end else if (line_start_i) begin
      ped_q <= ped_nxt;
      ttx_q <= ttx_nxt;
    end
  end

  assign ped_suppress_o = ped_q;
  assign ttx_insert_o   = ttx_q;

endmodule

// File: rtl/vbi_line_enable.sv
module vbi_line_enable #(
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 8,
  parameter int LINE_W     = 10,
  parameter int WIN_LINES  = 16,
  parameter int FIRST_LINE = 7,
  parameter int BASE_ADDR  = 'h15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              field_odd_i,
  input  logic [LINE_W-1:0] line_num_i,
  input  logic              mode_pal_i,
  input  logic              line_start_i,
  output logic              ped_suppress_o,
  output logic              ttx_insert_o
);

  logic                 rst_n_sync;
  logic [WIN_LINES-1:0] odd_mask;
  logic [WIN_LINES-1:0] even_mask;
  logic                 line_flag;

  vbi_le_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_n_sync)
  );

  vbi_le_regs #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .WIN_LINES (WIN_LINES),
    .BASE_ADDR (BASE_ADDR)
  ) u_regs (
    .clk         (clk),
    .rst_ni      (rst_n_sync),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .odd_mask_o  (odd_mask),
    .even_mask_o (even_mask)
  );

  vbi_le_lookup #(
    .LINE_W     (LINE_W),
    .WIN_LINES  (WIN_LINES),
    .FIRST_LINE (FIRST_LINE)
  ) u_lookup (
    .odd_mask_i  (odd_mask),
    .even_mask_i (even_mask),
    .field_odd_i (field_odd_i),
    .line_num_i  (line_num_i),
    .line_flag_o (line_flag)
  );

  vbi_le_out u_out (
    .clk            (clk),
    .rst_ni         (rst_n_sync),
    .line_start_i   (line_start_i),
    .line_flag_i    (line_flag),
    .mode_pal_i     (mode_pal_i),
    .ped_suppress_o (ped_suppress_o),
    .ttx_insert_o   (ttx_insert_o)
  );

endmodule

// File: rtl/vbi_line_enable_chk.sv
module vbi_line_enable_chk #(
  parameter int LINE_W     = 10,
  parameter int WIN_LINES  = 16,
  parameter int FIRST_LINE = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              line_start_i,
  input logic              mode_pal_i,
  input logic [LINE_W-1:0] line_num_i,
  input logic              ped_suppress_o,
  input logic              ttx_insert_o
);

  localparam int LAST_LINE = FIRST_LINE + WIN_LINES - 1;

  logic outside;
  assign outside = (line_num_i < LINE_W'(FIRST_LINE)) ||
                   (line_num_i > LINE_W'(LAST_LINE));

  AST_HOLD_BETWEEN_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start_i |=> ($stable(ped_suppress_o) && $stable(ttx_insert_o))); // R8

  AST_NTSC_NO_TELETEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start_i && !mode_pal_i) |=> !ttx_insert_o); // R5

  AST_PAL_NO_PED_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start_i && mode_pal_i) |=> !ped_suppress_o); // R6

  AST_OUTSIDE_WINDOW_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start_i && outside) |=> (!ped_suppress_o && !ttx_insert_o)); // R7

endmodule

bind vbi_line_enable vbi_line_enable_chk #(
  .LINE_W     (LINE_W),
  .WIN_LINES  (WIN_LINES),
  .FIRST_LINE (FIRST_LINE)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .line_start_i   (line_start_i),
  .mode_pal_i     (mode_pal_i),
  .line_num_i     (line_num_i),
  .ped_suppress_o (ped_suppress_o),
  .ttx_insert_o   (ttx_insert_o)
);

// File: tb/vbi_line_enable_test.sv
module vbi_line_enable_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [4:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       field_odd_i = 1'b0;
  logic [9:0] line_num_i = '0;
  logic       mode_pal_i = 1'b0;
  logic       line_start_i = 1'b0;
  logic       ped_suppress_o;
  logic       ttx_insert_o;

  int  nchk = 0;
  int  nfail = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  vbi_line_enable uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en_i        (wr_en_i),
    .wr_addr_i      (wr_addr_i),
    .wr_data_i      (wr_data_i),
    .field_odd_i    (field_odd_i),
    .line_num_i     (line_num_i),
    .mode_pal_i     (mode_pal_i),
    .line_start_i   (line_start_i),
    .ped_suppress_o (ped_suppress_o),
    .ttx_insert_o   (ttx_insert_o)
  );

  // Vector layout: {odd, line[9:0], pal, exp_ped, exp_ttx}
  // Odd mask 0xA5C3 -> lines 7,8,13,14,15,17,20,22 set.
  // Even mask 0x3C96 -> lines 8,9,11,14,17,18,19,20 set.
  localparam int NV = 16;
  localparam logic [13:0] VECS [NV] = '{
    {1'b1, 10'd7,    1'b0, 1'b1, 1'b0},
    {1'b1, 10'd7,    1'b1, 1'b0, 1'b1},
    {1'b1, 10'd9,    1'b0, 1'b0, 1'b0},
    {1'b1, 10'd22,   1'b1, 1'b0, 1'b1},
    {1'b1, 10'd23,   1'b1, 1'b0, 1'b0},
    {1'b1, 10'd6,    1'b0, 1'b0, 1'b0},
    {1'b0, 10'd7,    1'b0, 1'b0, 1'b0},
    {1'b0, 10'd8,    1'b1, 1'b0, 1'b1},
    {1'b0, 10'd20,   1'b0, 1'b1, 1'b0},
    {1'b0, 10'd21,   1'b0, 1'b0, 1'b0},
    {1'b1, 10'd20,   1'b0, 1'b1, 1'b0},
    {1'b0, 10'd13,   1'b1, 1'b0, 1'b0},
    {1'b1, 10'd15,   1'b1, 1'b0, 1'b1},
    {1'b0, 10'd0,    1'b1, 1'b0, 1'b0},
    {1'b0, 10'd22,   1'b1, 1'b0, 1'b0},
    {1'b1, 10'd1023, 1'b0, 1'b0, 1'b0}
  };

  task automatic check(input string tag, input logic exp_ped, input logic exp_ttx);
    nchk++;
    if (ped_suppress_o !== exp_ped || ttx_insert_o !== exp_ttx) begin
      nfail++;
      $display("FAIL %s: ped=%0b ttx=%0b expected ped=%0b ttx=%0b",
               tag, ped_suppress_o, ttx_insert_o, exp_ped, exp_ttx);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  // Strobe one line; returns on the falling edge after the update edge.
  task automatic strobe(input logic odd, input logic [9:0] ln, input logic pal);
    @(negedge clk);
    field_odd_i = odd; line_num_i = ln; mode_pal_i = pal; line_start_i = 1'b1;
    @(negedge clk);
    line_start_i = 1'b0;
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL R8 watchdog: run did not finish, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 outputs during reset", 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: masks start cleared
    strobe(1'b1, 10'd7, 1'b0);
    check("R1 cleared odd mask NTSC", 1'b0, 1'b0);
    strobe(1'b0, 10'd8, 1'b1);
    check("R1 cleared even mask PAL", 1'b0, 1'b0);

    // R2: program masks through the address map
    wr(5'h15, 8'hC3);
    wr(5'h16, 8'hA5);
    wr(5'h17, 8'h96);
    wr(5'h18, 8'h3C);

    // R3 R4 R5 R6 R7 table walk
    for (int i = 0; i < NV; i++) begin
      strobe(VECS[i][13], VECS[i][12:3], VECS[i][2]);
      check($sformatf("R3/R4/R5/R6/R7 vector %0d", i), VECS[i][1], VECS[i][0]);
    end

    // R8: hold between strobes despite input and register changes
    strobe(1'b1, 10'd7, 1'b0);
    check("R8 setup odd line 7 NTSC", 1'b1, 1'b0);
    @(negedge clk);
    field_odd_i = 1'b0; line_num_i = 10'd9; mode_pal_i = 1'b1;
    wr(5'h15, 8'h00);
    repeat (3) @(negedge clk);
    check("R8 hold without strobe", 1'b1, 1'b0);
    wr(5'h15, 8'hC3);

    // R9: write coinciding with strobe applies from next strobe
    @(negedge clk);
    field_odd_i = 1'b1; line_num_i = 10'd7; mode_pal_i = 1'b0; line_start_i = 1'b1;
    wr_en_i = 1'b1; wr_addr_i = 5'h15; wr_data_i = 8'h00;
    @(negedge clk);
    line_start_i = 1'b0; wr_en_i = 1'b0;
    check("R9 same-cycle write not seen", 1'b1, 1'b0);
    strobe(1'b1, 10'd7, 1'b0);
    check("R9 write seen at next strobe", 1'b0, 1'b0);

    // R10: out-of-map addresses leave masks untouched
    wr(5'h14, 8'hFF);
    wr(5'h19, 8'hFF);
    wr(5'h05, 8'hFF);
    strobe(1'b1, 10'd9, 1'b0);
    check("R10 odd low byte unchanged", 1'b0, 1'b0);
    strobe(1'b0, 10'd21, 1'b0);
    check("R10 even high byte unchanged", 1'b0, 1'b0);
    strobe(1'b0, 10'd7, 1'b1);
    check("R10 even low byte unchanged", 1'b0, 1'b0);

    // R2: top bit of even high byte governs line 22
    wr(5'h18, 8'h80);
    strobe(1'b0, 10'd22, 1'b1);
    check("R2 even bit15 line 22 PAL", 1'b0, 1'b1);
    strobe(1'b0, 10'd20, 1'b1);
    check("R2 even high byte rewritten", 1'b0, 1'b0);
    strobe(1'b1, 10'd22, 1'b0);
    check("R2 odd bit15 still set", 1'b1, 1'b0);

    // R1: reset in mid-run clears outputs and masks
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 outputs cleared by reset", 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    strobe(1'b1, 10'd20, 1'b0);
    check("R1 odd mask cleared after reset", 1'b0, 1'b0);
    strobe(1'b0, 10'd22, 1'b1);
    check("R1 even mask cleared after reset", 1'b0, 1'b0);
    apply_reset();
    check("R1 idle after second reset", 1'b0, 1'b0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule